// File: doc/BRIEF.md
# EEE Low-Power-Idle Transmit Controller

This block decides when the transmit side of a gigabit MAC may drop into Energy Efficient Ethernet low-power idle (LPI), and when it must come back out. Software sets it up through two 32-bit words. The control word carries the enable, automatic-entry and link-good bits, together with the event flags. The timer word carries the link-stable time and the wake time. Two timebase strobes pace the counters: one pulses once per millisecond and one pulses once per microsecond.

LPI begins only after the link has been good for the programmed number of milliseconds and the transmit path has been quiet. While LPI lasts, the block drives `lpi_assert_o` toward the PHY interface. A pending frame ends LPI, and so does a drop in any entry condition. After LPI ends, `tx_hold_o` keeps new frames back until the programmed number of microseconds has passed.

Entry into and exit from LPI are recorded as flags, on the transmit side and on the receive side. The receive side is seen through an input flag. Any set flag drives the interrupt. A read of the control word clears all the flags.

Top module: `eee_lpi_tx_ctrl`

## Requirements
- R1: The timer word (address 1) holds the wake time in bits 15:0 and the link-stable time in bits 26:16. It reads back as written, and every other bit reads as 0.
- R2: LPI is entered only when the link-stable counter has reached the programmed millisecond count. The counter steps on each `tick_ms_i`, and it restarts from 0 whenever `link_up_i` is low or the link-good bit is clear. With the strobe high on every cycle, entry happens LS+1 cycles after the write that sets the link-good bit.
- R3: `tx_hold_o` is high while in LPI and stays high after exit. A wake counter is loaded with TW at exit and counts down on `tick_us_i`, and the hold drops one cycle after that counter reaches 0. With the strobe high on every cycle, the hold lasts TW+1 cycles after exit. With no strobe, the hold never drops.
- R4: While the link-good bit (control bit 10) is clear, LPI is never entered.
- R5: Entry requires all of the following: enable (control bit 8), automatic entry (control bit 9), `tx_idle_i` high at this edge and at the previous edge, and `tx_req_i` low. `lpi_assert_o` rises one cycle after these conditions hold.
- R6: In LPI, any of the following starts the exit: a high `tx_req_i`, clearing the enable bit, or clearing the automatic-entry bit. `lpi_assert_o` falls at the next edge, and the transmit-exit flag is set.
- R7: The control word keeps four event flags: bit 0 is transmit entered, bit 1 is transmit exited, bit 2 is a rise of `rx_lpi_i`, and bit 3 is a fall of `rx_lpi_i`. Bit 16 reads as transmit-in-LPI and bit 17 reads as the registered `rx_lpi_i`. `irq_o` is high while any flag is set.
- R8: A read of the control word (address 0) clears all four flags and the interrupt. A flag that is set in the same cycle as the read survives the clear and shows on the next read.
- R9: After reset, both words read 0, and `lpi_assert_o`, `tx_hold_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Word select: 0 is control/status, 1 is timer |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe; a read of word 0 clears the flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| link_up_i | input | 1 | Link status from the PHY side |
| tx_idle_i | input | 1 | Transmit path is idle |
| tx_req_i | input | 1 | A frame is pending |
| rx_lpi_i | input | 1 | Receive path is in LPI |
| tick_ms_i | input | 1 | One-cycle strobe each millisecond |
| tick_us_i | input | 1 | One-cycle strobe each microsecond |
| lpi_assert_o | output | 1 | Requests LPI signalling |
| tx_hold_o | output | 1 | Holds back new frames |
| irq_o | output | 1 | Any event flag is set |

## Verification
The bench places the entry edge exactly. It breaks the link once while the count is in progress and checks that LPI then needs the full count again. A counter that did not restart, or was off by one, would enter a cycle early. It sweeps the wake time over 0 to 5 and the link-stable time over 0 to 4, and compares the hold length and the entry delay with TW+1 and LS+1. An off-by-one in either place shows up as a wrong count. It also makes a receive-LPI edge coincide with a clearing read. A design that gave the clear priority would lose that flag, and the next read would show 0 where bit 3 is expected.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    localparam int EV_N        = 4;
    localparam int EV_TX_ENTER = 0;
    localparam int EV_TX_EXIT  = 1;
    localparam int EV_RX_ENTER = 2;
    localparam int EV_RX_EXIT  = 3;

    localparam int CTRL_EN     = 8;
    localparam int CTRL_AUTO   = 9;
    localparam int CTRL_PLS    = 10;
    localparam int STAT_TX_LPI = 16;
    localparam int STAT_RX_LPI = 17;

    localparam int TIMER_LS_LSB = 16;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_TIMER = 1'b1;

endpackage

// File: rtl/eee_lpi_link_qual.sv
module eee_lpi_link_qual #(
    parameter int LS_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pls_i,
    input  logic            link_up_i,
    input  logic            tick_ms_i,
    input  logic [LS_W-1:0] limit_i,
    output logic [LS_W-1:0] cnt_o,
    output logic            ok_o
);
    typedef struct packed {
        logic [LS_W-1:0] cnt;
    } lq_state_t;

    lq_state_t st_d, st_q;
    logic      good;

    always_comb begin
        good = pls_i & link_up_i;
        st_d = st_q;
        if (!good) begin
            st_d.cnt = '0;
        end else if (tick_ms_i && (st_q.cnt < limit_i)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ok_o  = good && (st_q.cnt >= limit_i);
endmodule

// File: rtl/eee_lpi_wake_timer.sv
module eee_lpi_wake_timer #(
    parameter int TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [TW_W-1:0] load_val_i,
    input  logic            tick_us_i,
    output logic            zero_o
);
    typedef struct packed {
        logic [TW_W-1:0] cnt;
    } wt_state_t;

    wt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_us_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign zero_o = (st_q.cnt == '0);
endmodule

// File: rtl/eee_lpi_evt.sv
module eee_lpi_evt #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } ev_state_t;

    ev_state_t    st_d, st_q;
    logic [N-1:0] flag_nxt;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // a new event wins over a clearing read in the same cycle
        assign flag_nxt[i] = set_i[i] | (st_q.flags[i] & ~clr_i);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = flag_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |st_q.flags;
endmodule

// File: rtl/eee_lpi_tx_ctrl.sv
module eee_lpi_tx_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int TW_W = 16,
    parameter int LS_W = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_addr,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        link_up_i,
    input  logic        tx_idle_i,
    input  logic        tx_req_i,
    input  logic        rx_lpi_i,
    input  logic        tick_ms_i,
    input  logic        tick_us_i,
    output logic        lpi_assert_o,
    output logic        tx_hold_o,
    output logic        irq_o
);
    localparam int LS_MSB = TIMER_LS_LSB + LS_W - 1;

    typedef struct packed {
        lpi_state_e      st;
        logic            en;
        logic            autom;
        logic            pls;
        logic [TW_W-1:0] tw;
        logic [LS_W-1:0] ls;
        logic            idle_q;
        logic            rx_q;
    } ctl_state_t;

    ctl_state_t      cur_q, nxt_d;
    logic [EV_N-1:0] ev_set;
    logic [EV_N-1:0] ev_flags;
    logic            ev_clr;
    logic            wake_load;
    logic            wake_zero;
    logic            link_ok;
    logic            enter_ok;
    logic            leave_req;
    logic [LS_W-1:0] ls_cnt_w;
    logic            pls_w;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign pls_w        = cur_q.pls;
    assign ev_clr       = reg_rd_en && (reg_addr == ADDR_CTRL);

    eee_lpi_link_qual #(.LS_W(LS_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .pls_i     (cur_q.pls),
        .link_up_i (link_up_i),
        .tick_ms_i (tick_ms_i),
        .limit_i   (cur_q.ls),
        .cnt_o     (ls_cnt_w),
        .ok_o      (link_ok)
    );

    eee_lpi_wake_timer #(.TW_W(TW_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wake_load),
        .load_val_i (cur_q.tw),
        .tick_us_i  (tick_us_i),
        .zero_o     (wake_zero)
    );

    eee_lpi_evt #(.N(EV_N)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (ev_clr),
        .flags_o (ev_flags),
        .irq_o   (irq_o)
    );

    always_comb begin
        nxt_d     = cur_q;
        ev_set    = '0;
        wake_load = 1'b0;

        if (reg_wr_en) begin
            if (reg_addr == ADDR_CTRL) begin
                nxt_d.en    = reg_wdata[CTRL_EN];
                nxt_d.autom = reg_wdata[CTRL_AUTO];
                nxt_d.pls   = reg_wdata[CTRL_PLS];
            end else begin
                nxt_d.tw = reg_wdata[TW_W-1:0];
                nxt_d.ls = reg_wdata[LS_MSB:TIMER_LS_LSB];
            end
        end

        nxt_d.idle_q = tx_idle_i;
        nxt_d.rx_q   = rx_lpi_i;
        ev_set[EV_RX_ENTER] = rx_lpi_i & ~cur_q.rx_q;
        ev_set[EV_RX_EXIT]  = ~rx_lpi_i & cur_q.rx_q;

        enter_ok  = cur_q.en & cur_q.autom & link_ok &
                    tx_idle_i & cur_q.idle_q & ~tx_req_i;
        leave_req = tx_req_i | ~cur_q.en | ~cur_q.autom | ~link_ok;

        case (cur_q.st)
            ST_ACTIVE: begin
                if (enter_ok) begin
                    nxt_d.st            = ST_LPI;
                    ev_set[EV_TX_ENTER] = 1'b1;
                end
            end
            ST_LPI: begin
                if (leave_req) begin
                    nxt_d.st           = ST_WAKE;
                    wake_load          = 1'b1;
                    ev_set[EV_TX_EXIT] = 1'b1;
                end
            end
            ST_WAKE: begin
                if (wake_zero) nxt_d.st = ST_ACTIVE;
            end
            default: nxt_d.st = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_ACTIVE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[EV_N-1:0]   = ev_flags;
            reg_rdata[CTRL_EN]    = cur_q.en;
            reg_rdata[CTRL_AUTO]  = cur_q.autom;
            reg_rdata[CTRL_PLS]   = cur_q.pls;
            reg_rdata[STAT_TX_LPI] = (cur_q.st == ST_LPI);
            reg_rdata[STAT_RX_LPI] = cur_q.rx_q;
        end else begin
            reg_rdata[TW_W-1:0]           = cur_q.tw;
            reg_rdata[LS_MSB:TIMER_LS_LSB] = cur_q.ls;
        end
    end

    assign lpi_assert_o = (cur_q.st == ST_LPI);
    assign tx_hold_o    = (cur_q.st != ST_ACTIVE);
endmodule

// File: rtl/eee_lpi_chk.sv
module eee_lpi_chk #(
    parameter int LS_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lpi_assert_o,
    input logic            tx_hold_o,
    input logic            tx_idle_i,
    input logic            tx_req_i,
    input logic            pls,
    input logic [LS_W-1:0] ls_cnt,
    input logic [LS_W-1:0] ls_lim,
    input logic [3:0]      flags
);
    assert_hold_in_lpi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_assert_o |-> tx_hold_o);

    assert_hold_after_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_assert_o) |-> tx_hold_o);

    assert_link_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_assert_o) |-> ($past(ls_cnt) >= $past(ls_lim)));

    assert_pls_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_assert_o) |-> $past(pls));

    assert_idle_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_assert_o) |-> ($past(tx_idle_i) && !$past(tx_req_i)));

    assert_enter_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_assert_o) |-> flags[0]);

    assert_exit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_assert_o) |-> flags[1]);
endmodule

bind eee_lpi_tx_ctrl eee_lpi_chk #(.LS_W(LS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lpi_assert_o (lpi_assert_o),
    .tx_hold_o    (tx_hold_o),
    .tx_idle_i    (tx_idle_i),
    .tx_req_i     (tx_req_i),
    .pls          (pls_w),
    .ls_cnt       (ls_cnt_w),
    .ls_lim       (cur_q.ls),
    .flags        (ev_flags)
);

// File: tb/eee_lpi_tx_ctrl_tb.sv
module eee_lpi_tx_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_addr = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_up_i = 1'b0;
    logic        tx_idle_i = 1'b0;
    logic        tx_req_i = 1'b0;
    logic        rx_lpi_i = 1'b0;
    logic        tick_ms_i = 1'b0;
    logic        tick_us_i = 1'b0;
    logic        lpi_assert_o;
    logic        tx_hold_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eee_lpi_tx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .link_up_i(link_up_i), .tx_idle_i(tx_idle_i), .tx_req_i(tx_req_i),
        .rx_lpi_i(rx_lpi_i), .tick_ms_i(tick_ms_i), .tick_us_i(tick_us_i),
        .lpi_assert_o(lpi_assert_o), .tx_hold_o(tx_hold_o), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        reg_addr = a; reg_rd_en = 1'b1;
        #1;
        d = reg_rdata;
        step();
        reg_rd_en = 1'b0;
    endtask

    task automatic ms_pulse();
        tick_ms_i = 1'b1; step(); tick_ms_i = 1'b0;
    endtask

    task automatic us_pulse();
        tick_us_i = 1'b1; step(); tick_us_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R9 reset state
        chk("R9 lpi", {31'b0, lpi_assert_o}, 32'd0);
        chk("R9 hold", {31'b0, tx_hold_o}, 32'd0);
        chk("R9 irq", {31'b0, irq_o}, 32'd0);
        rd(1'b0, v); chk("R9 ctrl", v, 32'h0);
        rd(1'b1, v); chk("R9 timer", v, 32'h0);

        // R1 field layout
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk("R1 mask", v, 32'h07FF_FFFF);
        wr(1'b1, 32'h0003_0004);
        rd(1'b1, v); chk("R1 value", v, 32'h0003_0004);

        // R4 link-good bit clear blocks entry
        link_up_i = 1'b1; tx_idle_i = 1'b1;
        wr(1'b0, 32'h0000_0300);
        repeat (5) ms_pulse();
        repeat (3) step();
        chk("R4 no entry", {31'b0, lpi_assert_o}, 32'd0);
        rd(1'b0, v); chk("R4 ctrl", v, 32'h0000_0300);

        // R2 link-stable count with restart
        wr(1'b0, 32'h0000_0700);
        ms_pulse(); ms_pulse();
        link_up_i = 1'b0; step(); link_up_i = 1'b1;
        ms_pulse(); ms_pulse(); step();
        chk("R2 restart", {31'b0, lpi_assert_o}, 32'd0);
        ms_pulse();
        chk("R2 before edge", {31'b0, lpi_assert_o}, 32'd0);
        step();
        chk("R2 entry", {31'b0, lpi_assert_o}, 32'd1);
        chk("R3 hold in lpi", {31'b0, tx_hold_o}, 32'd1);

        // R7 / R8 flags and clearing read
        chk("R7 irq", {31'b0, irq_o}, 32'd1);
        rd(1'b0, v); chk("R7 ctrl enter", v, 32'h0001_0701);
        chk("R8 irq cleared", {31'b0, irq_o}, 32'd0);
        rd(1'b0, v); chk("R8 ctrl cleared", v, 32'h0001_0700);

        // R6 exit on frame request, R3 wake timing
        tx_idle_i = 1'b0; tx_req_i = 1'b1;
        step();
        tx_req_i = 1'b0;
        chk("R6 exit on req", {31'b0, lpi_assert_o}, 32'd0);
        chk("R3 hold after exit", {31'b0, tx_hold_o}, 32'd1);
        repeat (4) us_pulse();
        chk("R3 hold at zero", {31'b0, tx_hold_o}, 32'd1);
        step();
        chk("R3 release", {31'b0, tx_hold_o}, 32'd0);
        rd(1'b0, v); chk("R6 exit flag", v, 32'h0000_0702);

        // R5 idle qualification and pending frame
        tx_idle_i = 1'b1; tx_req_i = 1'b1;
        repeat (3) step();
        chk("R5 req blocks", {31'b0, lpi_assert_o}, 32'd0);
        tx_idle_i = 1'b0; step();
        tx_idle_i = 1'b1; tx_req_i = 1'b0; step();
        chk("R5 one idle cycle", {31'b0, lpi_assert_o}, 32'd0);
        step();
        chk("R5 entry", {31'b0, lpi_assert_o}, 32'd1);

        // R6 exit on clearing enable/automatic bits, R3 no tick no release
        rd(1'b0, v);
        wr(1'b0, 32'h0000_0400);
        chk("R6 still lpi", {31'b0, lpi_assert_o}, 32'd1);
        step();
        chk("R6 exit on disable", {31'b0, lpi_assert_o}, 32'd0);
        rd(1'b0, v); chk("R6 disable flag", v, 32'h0000_0402);
        repeat (10) step();
        chk("R3 hold without ticks", {31'b0, tx_hold_o}, 32'd1);
        repeat (4) us_pulse();
        step();
        chk("R3 release late", {31'b0, tx_hold_o}, 32'd0);

        // R7 / R8 receive flags and read collision
        rx_lpi_i = 1'b1; step();
        rd(1'b0, v); chk("R7 rx enter", v, 32'h0002_0404);
        rx_lpi_i = 1'b0;
        rd(1'b0, v); chk("R8 before collision", v, 32'h0002_0400);
        rd(1'b0, v); chk("R8 survives clear", v, 32'h0000_0408);
        chk("R8 irq after", {31'b0, irq_o}, 32'd0);

        // R3 sweep of wake time
        tick_us_i = 1'b1;
        for (int tw = 0; tw < 6; tw++) begin
            wr(1'b1, tw);
            wr(1'b0, 32'h0000_0700);
            tx_idle_i = 1'b1; tx_req_i = 1'b0;
            n = 0;
            while (lpi_assert_o !== 1'b1 && n < 20) begin step(); n++; end
            chk($sformatf("R5 sweep entry tw=%0d", tw), {31'b0, lpi_assert_o}, 32'd1);
            tx_req_i = 1'b1; tx_idle_i = 1'b0;
            step();
            tx_req_i = 1'b0;
            n = 0;
            while (tx_hold_o === 1'b1 && n < 40) begin step(); n++; end
            chk($sformatf("R3 hold length tw=%0d", tw), n, tw + 1);
        end
        tick_us_i = 1'b0;

        // R2 sweep of link-stable time
        tick_ms_i = 1'b1;
        for (int ls = 0; ls < 5; ls++) begin
            wr(1'b0, 32'h0);
            tx_idle_i = 1'b1;
            repeat (3) step();
            wr(1'b1, ls << 16);
            wr(1'b0, 32'h0000_0700);
            n = 0;
            while (lpi_assert_o !== 1'b1 && n < 40) begin step(); n++; end
            chk($sformatf("R2 entry delay ls=%0d", ls), n, ls + 1);
        end
        tick_ms_i = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule